// File: doc/BRIEF.md
# Rename Stage Stall Controller

This block is the per-thread control core of the rename stage of an out-of-order pipeline. Each cycle it looks at how many instructions decode is offering, how much room is left in the reorder buffer, the issue queue and the load/store queue, and whether any later stage asks rename to stop. From that it decides how many instructions may be renamed, how many go into or come out of the skid buffer, whether decode must hold off, and which back-end structure is the limit. The register mapping, the free list and the instruction storage itself sit outside; this block only produces the counts and the state that steer them.

Each thread runs its own seven-state machine (running, idle, start of squash, squashing, blocked, unblocking, serialize wait). The machine keeps three pieces of state per thread: the skid-buffer occupancy, the number of instructions that have been renamed but are not yet counted in downstream occupancy (the in-flight count), and a pending flag that marks the next instruction as serializing. A single activity flag, derived from all threads, tells the rest of the core whether rename has work.

Pending instructions are taken from the skid buffer when it holds anything, otherwise straight from decode, so program order is always kept.

Top module: `rename_stall_ctrl`

## Requirements
- R1: After synchronous reset every thread is in the idle state (state code 1), the skid buffer is empty, decode is not blocked, the grant is 0 and the activity flag is low.
- R2: The grant of a thread is the smallest of WIDTH, the pending count (skid occupancy if non-zero, else the decode count, capped at WIDTH) and, for each of the three structures, its free count minus the in-flight count (floored at 0); a serializing head instruction lowers the request to 1.
- R3: The cause output reports, against the requested count, the first structure whose headroom is too small in the order reorder buffer (code 0), issue queue (1), load/store queue (2), otherwise none (3); it reads 3 during a squash and in the two squash states.
- R4: Decode instructions not renamed are written to the skid buffer; when the skid buffer is non-zero all decode instructions go to it and the grant is read from it. A grant smaller than the request moves the thread to the blocked state (code 4).
- R5: A stall request from execute or from commit gives a grant of 0 in that cycle and puts the thread in the blocked state in the next cycle.
- R6: A blocked thread with no stall request moves to unblocking (code 5) with grant 0; a thread that renames moves to running (code 0) only if its skid buffer is empty afterwards, to unblocking if not, and to idle when nothing was requested.
- R7: The block-to-decode output is high exactly when skid occupancy exceeds SKID_MAX minus WIDTH, so a decode that obeys it never overflows the skid buffer.
- R8: A serializing head instruction renames alone (grant 1) and only when the reorder-buffer-empty input is high and the in-flight count is 0; until then the thread is held in serialize wait (code 6) with grant 0.
- R9: A serialize-after pulse makes the next instruction to be renamed serializing; the mark is cleared when a serializing instruction is renamed or on a squash.
- R10: The in-flight count grows by the grant and shrinks by the landing count each cycle, floored at 0, and is cleared by a squash.
- R11: A squash request puts the thread in start-squash (code 2) the next cycle, or in squashing (code 3) if it was already squashing; it empties the skid buffer, drops decode input, gives grant 0, and once released the thread returns to idle.
- R12: The activity output is high when any thread is in a state other than idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_cnt_i | input | NTHREADS*GW | Instructions offered by decode per thread (at most WIDTH) |
| free_rob_i | input | NTHREADS*CNT_W | Free reorder-buffer entries per thread |
| free_iq_i | input | NTHREADS*CNT_W | Free issue-queue entries per thread |
| free_lsq_i | input | NTHREADS*CNT_W | Free load/store-queue entries per thread |
| land_cnt_i | input | NTHREADS*GW | Renamed instructions now counted downstream |
| stall_exe_i | input | NTHREADS | Stall request from execute |
| stall_cmt_i | input | NTHREADS | Stall request from commit |
| squash_i | input | NTHREADS | Squash request |
| rob_empty_i | input | NTHREADS | Reorder buffer empty |
| ser_head_i | input | NTHREADS | Oldest pending instruction is serializing |
| ser_after_i | input | NTHREADS | Mark the next instruction as serializing |
| grant_o | output | NTHREADS*GW | Instructions renamed this cycle |
| skid_wr_o | output | NTHREADS*GW | Instructions written to the skid buffer |
| skid_rd_o | output | NTHREADS*GW | Instructions taken from the skid buffer |
| block_dec_o | output | NTHREADS | Tell decode to hold |
| cause_o | output | NTHREADS*2 | Structure-full cause |
| state_o | output | NTHREADS*3 | Thread state code |
| active_o | output | 1 | Any thread not idle |

## Verification
The hardest state to reach is a serialize wait that is released by the in-flight count rather than by the reorder-buffer flag: the bench stops landing renamed instructions so the in-flight count stays above zero, raises the empty flag first, and only then lands the remainder so the single-instruction grant appears one cycle later. A second hard corner is a skid buffer at its blocking threshold being emptied by a squash in the same cycle decode offers more; the bench fills the skid under a stall before squashing. A long pseudo-random run mixes stalls, squashes, shortages and serialization on both threads against a cycle model.

// File: rtl/rn_pkg.sv
package rn_pkg;

    typedef enum logic [2:0] {
        ST_RUN       = 3'd0,
        ST_IDLE      = 3'd1,
        ST_SQ_START  = 3'd2,
        ST_SQUASHING = 3'd3,
        ST_BLOCKED   = 3'd4,
        ST_UNBLOCK   = 3'd5,
        ST_SER_WAIT  = 3'd6
    } rn_state_e;

    typedef enum logic [1:0] {
        FC_ROB  = 2'd0,
        FC_IQ   = 2'd1,
        FC_LSQ  = 2'd2,
        FC_NONE = 2'd3
    } full_cause_e;

    localparam int NUM_RES = 3;

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    function automatic int sat_sub(input int a, input int b);
        return (a > b) ? (a - b) : 0;
    endfunction

    function automatic logic is_squash_state(input rn_state_e s);
        return (s == ST_SQ_START) || (s == ST_SQUASHING);
    endfunction

endpackage

// File: rtl/rn_headroom.sv
module rn_headroom
    import rn_pkg::*;
#(
    parameter int WIDTH = 4,
    parameter int CNT_W = 6,
    parameter int GW    = 3
) (
    input  logic [NUM_RES-1:0][CNT_W-1:0] free_i,
    input  logic [CNT_W-1:0]              inflight_i,
    input  logic [GW-1:0]                 want_i,
    output logic [GW-1:0]                 cap_o,
    output full_cause_e                   cause_o
);

    logic [NUM_RES-1:0][CNT_W-1:0] avail;

    for (genvar r = 0; r < NUM_RES; r++) begin : g_res
        assign avail[r] = (free_i[r] > inflight_i) ? (free_i[r] - inflight_i) : '0;
    end

    always_comb begin
        int c;
        c = WIDTH;
        for (int r = 0; r < NUM_RES; r++) begin
            c = imin(c, int'(avail[r]));
        end
        cap_o = GW'(c);
    end

    // lowest index wins: reorder buffer, then issue queue, then load/store queue
    always_comb begin
        cause_o = FC_NONE;
        for (int r = NUM_RES - 1; r >= 0; r--) begin
            if (int'(avail[r]) < int'(want_i)) begin
                cause_o = full_cause_e'(2'(r));
            end
        end
    end

endmodule

// File: rtl/rn_skid_count.sv
module rn_skid_count #(
    parameter int WIDTH    = 4,
    parameter int SKID_MAX = 12,
    parameter int GW       = 3,
    parameter int QW       = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear_i,
    input  logic [GW-1:0] wr_i,
    input  logic [GW-1:0] rd_i,
    output logic [QW-1:0] occ_o,
    output logic          near_full_o
);

    localparam int THRESH = SKID_MAX - WIDTH;

    logic [QW-1:0] occ_d;

    always_comb begin
        if (clear_i) begin
            occ_d = '0;
        end else begin
            occ_d = QW'(int'(occ_o) + int'(wr_i) - int'(rd_i));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            occ_o <= '0;
        end else begin
            occ_o <= occ_d;
        end
    end

    assign near_full_o = int'(occ_o) > THRESH;

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
        int'(occ_o) <= SKID_MAX);

    a_r4_no_underflow: assert property (@(posedge clk) disable iff (rst)
        int'(rd_i) <= int'(occ_o));

endmodule

// File: rtl/rn_thread_ctl.sv
module rn_thread_ctl
    import rn_pkg::*;
#(
    parameter int WIDTH    = 4,
    parameter int SKID_MAX = 12,
    parameter int CNT_W    = 6,
    parameter int GW       = 3,
    parameter int QW       = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [GW-1:0]                 dec_cnt_i,
    input  logic [NUM_RES-1:0][CNT_W-1:0] free_i,
    input  logic [GW-1:0]                 land_i,
    input  logic                          stall_exe_i,
    input  logic                          stall_cmt_i,
    input  logic                          squash_i,
    input  logic                          rob_empty_i,
    input  logic                          ser_head_i,
    input  logic                          ser_after_i,
    output logic [GW-1:0]                 grant_o,
    output logic [GW-1:0]                 skid_wr_o,
    output logic [GW-1:0]                 skid_rd_o,
    output logic                          block_o,
    output full_cause_e                   cause_o,
    output rn_state_e                     state_o
);

    rn_state_e        state_q, state_d;
    logic [CNT_W-1:0] infl_q, infl_d;
    logic             ser_next_q, ser_next_d;
    logic [QW-1:0]    occ;
    logic             skid_clear;
    logic [GW-1:0]    want, cap;
    full_cause_e      hr_cause;
    logic             ser_eff, ser_ready, in_sq, stall_any, go;
    int               src_n, pend_n, g_n, wr_n, rd_n, q_after;

    // request side: where pending instructions come from and how many are asked
    always_comb begin
        src_n   = (occ != '0) ? int'(occ) : int'(dec_cnt_i);
        pend_n  = imin(src_n, WIDTH);
        ser_eff = (ser_head_i || ser_next_q) && (src_n > 0);
        want    = ser_eff ? GW'(1) : GW'(pend_n);
    end

    rn_headroom #(
        .WIDTH (WIDTH),
        .CNT_W (CNT_W),
        .GW    (GW)
    ) u_headroom (
        .free_i     (free_i),
        .inflight_i (infl_q),
        .want_i     (want),
        .cap_o      (cap),
        .cause_o    (hr_cause)
    );

    // decision side
    always_comb begin
        in_sq      = is_squash_state(state_q);
        stall_any  = stall_exe_i || stall_cmt_i;
        ser_ready  = rob_empty_i && (infl_q == '0);
        go         = 1'b0;
        g_n        = 0;
        wr_n       = 0;
        rd_n       = 0;
        q_after    = int'(occ);
        skid_clear = 1'b0;
        state_d    = state_q;
        if (squash_i) begin
            skid_clear = 1'b1;
            state_d    = in_sq ? ST_SQUASHING : ST_SQ_START;
        end else if (in_sq) begin
            state_d = ST_IDLE;
        end else begin
            if (stall_any) begin
                state_d = ST_BLOCKED;
            end else if (state_q == ST_BLOCKED) begin
                state_d = ST_UNBLOCK;
            end else if (ser_eff && !ser_ready) begin
                state_d = ST_SER_WAIT;
            end else begin
                go  = 1'b1;
                g_n = imin(int'(want), int'(cap));
            end
            if (occ != '0) begin
                wr_n = int'(dec_cnt_i);
                rd_n = g_n;
            end else begin
                wr_n = int'(dec_cnt_i) - g_n;
                rd_n = 0;
            end
            q_after = int'(occ) + wr_n - rd_n;
            if (go) begin
                if (g_n < int'(want)) begin
                    state_d = ST_BLOCKED;
                end else if (q_after > 0) begin
                    state_d = ST_UNBLOCK;
                end else if (g_n > 0) begin
                    state_d = ST_RUN;
                end else begin
                    state_d = ST_IDLE;
                end
            end
        end
    end

    always_comb begin
        if (squash_i) begin
            ser_next_d = 1'b0;
            infl_d     = '0;
        end else begin
            if (ser_after_i) begin
                ser_next_d = 1'b1;
            end else if (ser_eff && (g_n > 0)) begin
                ser_next_d = 1'b0;
            end else begin
                ser_next_d = ser_next_q;
            end
            infl_d = CNT_W'(sat_sub(int'(infl_q) + g_n, int'(land_i)));
        end
    end

    rn_skid_count #(
        .WIDTH    (WIDTH),
        .SKID_MAX (SKID_MAX),
        .GW       (GW),
        .QW       (QW)
    ) u_skid (
        .clk         (clk),
        .rst         (rst),
        .clear_i     (skid_clear),
        .wr_i        (skid_wr_o),
        .rd_i        (skid_rd_o),
        .occ_o       (occ),
        .near_full_o (block_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            infl_q     <= '0;
            ser_next_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            infl_q     <= infl_d;
            ser_next_q <= ser_next_d;
        end
    end

    assign grant_o   = GW'(g_n);
    assign skid_wr_o = GW'(wr_n);
    assign skid_rd_o = GW'(rd_n);
    assign cause_o   = (squash_i || in_sq) ? FC_NONE : hr_cause;
    assign state_o   = state_q;

    a_r11_squash_enter: assert property (@(posedge clk) disable iff (rst)
        squash_i |=> (state_q == ST_SQ_START || state_q == ST_SQUASHING));

    a_r11_skid_emptied: assert property (@(posedge clk) disable iff (rst)
        squash_i |=> (occ == '0));

    a_r10_inflight_cleared: assert property (@(posedge clk) disable iff (rst)
        squash_i |=> (infl_q == '0));

    a_r5_stall_blocks: assert property (@(posedge clk) disable iff (rst)
        (!squash_i && !in_sq && (stall_exe_i || stall_cmt_i)) |=> (state_q == ST_BLOCKED));

    a_r6_run_means_empty: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN) |-> (occ == '0));

    a_r8_serial_alone: assert property (@(posedge clk) disable iff (rst)
        (ser_head_i && (grant_o != '0)) |-> (grant_o == GW'(1)));

    a_r8_wait_holds: assert property (@(posedge clk) disable iff (rst)
        (ser_head_i && !rob_empty_i) |-> (grant_o == '0));

    a_r2_grant_bounded: assert property (@(posedge clk) disable iff (rst)
        int'(grant_o) <= WIDTH);

endmodule

// File: rtl/rename_stall_ctrl.sv
module rename_stall_ctrl
    import rn_pkg::*;
#(
    parameter int NTHREADS = 2,
    parameter int WIDTH    = 4,
    parameter int SKID_MAX = 12,
    parameter int CNT_W    = 6,
    localparam int GW      = $clog2(WIDTH + 1),
    localparam int QW      = $clog2(SKID_MAX + 1)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NTHREADS-1:0][GW-1:0]    dec_cnt_i,
    input  logic [NTHREADS-1:0][CNT_W-1:0] free_rob_i,
    input  logic [NTHREADS-1:0][CNT_W-1:0] free_iq_i,
    input  logic [NTHREADS-1:0][CNT_W-1:0] free_lsq_i,
    input  logic [NTHREADS-1:0][GW-1:0]    land_cnt_i,
    input  logic [NTHREADS-1:0]            stall_exe_i,
    input  logic [NTHREADS-1:0]            stall_cmt_i,
    input  logic [NTHREADS-1:0]            squash_i,
    input  logic [NTHREADS-1:0]            rob_empty_i,
    input  logic [NTHREADS-1:0]            ser_head_i,
    input  logic [NTHREADS-1:0]            ser_after_i,
    output logic [NTHREADS-1:0][GW-1:0]    grant_o,
    output logic [NTHREADS-1:0][GW-1:0]    skid_wr_o,
    output logic [NTHREADS-1:0][GW-1:0]    skid_rd_o,
    output logic [NTHREADS-1:0]            block_dec_o,
    output logic [NTHREADS-1:0][1:0]       cause_o,
    output logic [NTHREADS-1:0][2:0]       state_o,
    output logic                           active_o
);

    logic [NTHREADS-1:0] busy;

    for (genvar t = 0; t < NTHREADS; t++) begin : g_thr
        logic [NUM_RES-1:0][CNT_W-1:0] free_all;
        full_cause_e                   th_cause;
        rn_state_e                     th_state;

        assign free_all[0] = free_rob_i[t];
        assign free_all[1] = free_iq_i[t];
        assign free_all[2] = free_lsq_i[t];

        rn_thread_ctl #(
            .WIDTH    (WIDTH),
            .SKID_MAX (SKID_MAX),
            .CNT_W    (CNT_W),
            .GW       (GW),
            .QW       (QW)
        ) u_ctl (
            .clk         (clk),
            .rst         (rst),
            .dec_cnt_i   (dec_cnt_i[t]),
            .free_i      (free_all),
            .land_i      (land_cnt_i[t]),
            .stall_exe_i (stall_exe_i[t]),
            .stall_cmt_i (stall_cmt_i[t]),
            .squash_i    (squash_i[t]),
            .rob_empty_i (rob_empty_i[t]),
            .ser_head_i  (ser_head_i[t]),
            .ser_after_i (ser_after_i[t]),
            .grant_o     (grant_o[t]),
            .skid_wr_o   (skid_wr_o[t]),
            .skid_rd_o   (skid_rd_o[t]),
            .block_o     (block_dec_o[t]),
            .cause_o     (th_cause),
            .state_o     (th_state)
        );

        assign cause_o[t] = th_cause;
        assign state_o[t] = th_state;
        assign busy[t]    = (th_state != ST_IDLE);
    end

    assign active_o = |busy;

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !active_o |-> (grant_o == '0 || dec_cnt_i != '0));

endmodule

// File: tb/tb_rename_stall_ctrl.sv
module tb_rename_stall_ctrl;

    localparam int NT = 2;
    localparam int W  = 4;
    localparam int SM = 12;
    localparam int CW = 6;
    localparam int GW = $clog2(W + 1);

    logic                     clk = 1'b0;
    logic                     rst;
    logic [NT-1:0][GW-1:0]    dec_cnt;
    logic [NT-1:0][CW-1:0]    free_rob, free_iq, free_lsq;
    logic [NT-1:0][GW-1:0]    land_cnt;
    logic [NT-1:0]            stall_exe, stall_cmt, squash, rob_empty, ser_head, ser_after;
    logic [NT-1:0][GW-1:0]    grant, skid_wr, skid_rd;
    logic [NT-1:0]            block_dec;
    logic [NT-1:0][1:0]       cause;
    logic [NT-1:0][2:0]       state;
    logic                     active;

    rename_stall_ctrl #(.NTHREADS(NT), .WIDTH(W), .SKID_MAX(SM), .CNT_W(CW)) dut (
        .clk(clk), .rst(rst), .dec_cnt_i(dec_cnt), .free_rob_i(free_rob),
        .free_iq_i(free_iq), .free_lsq_i(free_lsq), .land_cnt_i(land_cnt),
        .stall_exe_i(stall_exe), .stall_cmt_i(stall_cmt), .squash_i(squash),
        .rob_empty_i(rob_empty), .ser_head_i(ser_head), .ser_after_i(ser_after),
        .grant_o(grant), .skid_wr_o(skid_wr), .skid_rd_o(skid_rd),
        .block_dec_o(block_dec), .cause_o(cause), .state_o(state), .active_o(active)
    );

    always #5 clk = ~clk;

    int    checks = 0;
    int    errors = 0;
    bit    finished = 1'b0;
    string cur_req = "R2";
    bit    auto_land = 1'b1;

    int m_st[NT];
    int m_q[NT];
    int m_f[NT];
    int m_sn[NT];

    function automatic int mn(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic set_land();
        for (int t = 0; t < NT; t++) begin
            if (auto_land) land_cnt[t] = GW'(mn(m_f[t], W));
        end
    endtask

    // inputs already driven at the falling edge; compare and advance the model
    task automatic step();
        int exp_act;
        set_land();
        #1;
        exp_act = 0;
        for (int t = 0; t < NT; t++) begin
            int dec, src, pend, want, ar, ai, al, cap, ecause, g, wr, rd;
            int nst, nq, nf, nsn, f;
            bit se, insq, stl, ready, go;
            f    = m_f[t];
            dec  = int'(dec_cnt[t]);
            src  = (m_q[t] > 0) ? m_q[t] : dec;
            pend = mn(src, W);
            se   = (ser_head[t] || m_sn[t] != 0) && src > 0;
            want = se ? 1 : pend;
            ar   = (int'(free_rob[t]) > f) ? int'(free_rob[t]) - f : 0;
            ai   = (int'(free_iq[t])  > f) ? int'(free_iq[t])  - f : 0;
            al   = (int'(free_lsq[t]) > f) ? int'(free_lsq[t]) - f : 0;
            cap  = mn(W, mn(ar, mn(ai, al)));
            ecause = (ar < want) ? 0 : (ai < want) ? 1 : (al < want) ? 2 : 3;
            insq = (m_st[t] == 2) || (m_st[t] == 3);
            stl  = stall_exe[t] || stall_cmt[t];
            ready = rob_empty[t] && (f == 0);
            g = 0; wr = 0; rd = 0; go = 0;
            nst = m_st[t]; nq = m_q[t]; nsn = m_sn[t];
            if (squash[t]) begin
                nst = insq ? 3 : 2; nq = 0; nf = 0; nsn = 0; ecause = 3;
            end else if (insq) begin
                nst = 1; ecause = 3;
                nf = (f > int'(land_cnt[t])) ? f - int'(land_cnt[t]) : 0;
                nsn = ser_after[t] ? 1 : m_sn[t];
            end else begin
                if (stl) nst = 4;
                else if (m_st[t] == 4) nst = 5;
                else if (se && !ready) nst = 6;
                else begin go = 1; g = mn(want, cap); end
                if (m_q[t] > 0) begin wr = dec; rd = g; end
                else begin wr = dec - g; rd = 0; end
                nq = m_q[t] + wr - rd;
                if (go) begin
                    if (g < want) nst = 4;
                    else if (nq > 0) nst = 5;
                    else if (g > 0) nst = 0;
                    else nst = 1;
                end
                nf = (f + g > int'(land_cnt[t])) ? f + g - int'(land_cnt[t]) : 0;
                nsn = ser_after[t] ? 1 : (se && g > 0) ? 0 : m_sn[t];
            end
            chk("R2", $sformatf("grant t%0d", t), int'(grant[t]), g);
            chk("R4", $sformatf("skid_wr t%0d", t), int'(skid_wr[t]), wr);
            chk("R4", $sformatf("skid_rd t%0d", t), int'(skid_rd[t]), rd);
            chk("R7", $sformatf("block t%0d", t), int'(block_dec[t]), (m_q[t] > SM - W) ? 1 : 0);
            chk("R3", $sformatf("cause t%0d", t), int'(cause[t]), ecause);
            chk(cur_req, $sformatf("state t%0d", t), int'(state[t]), m_st[t]);
            if (m_st[t] != 1) exp_act = 1;
            m_st[t] = nst; m_q[t] = nq; m_f[t] = nf; m_sn[t] = nsn;
        end
        chk("R12", "active", int'(active), exp_act);
        @(negedge clk);
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic free_all(input int t, input int r, input int i, input int l);
        free_rob[t] = CW'(r); free_iq[t] = CW'(i); free_lsq[t] = CW'(l);
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        dec_cnt = '0; land_cnt = '0; stall_exe = '0; stall_cmt = '0; squash = '0;
        rob_empty = '1; ser_head = '0; ser_after = '0;
        for (int t = 0; t < NT; t++) begin
            free_all(t, 15, 15, 15);
            m_st[t] = 1; m_q[t] = 0; m_f[t] = 0; m_sn[t] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        for (int t = 0; t < NT; t++) begin
            chk("R1", "reset state", int'(state[t]), 1);
            chk("R1", "reset grant", int'(grant[t]), 0);
            chk("R1", "reset block", int'(block_dec[t]), 0);
        end
        chk("R1", "reset active", int'(active), 0);

        // R2 plain renaming
        cur_req = "R2";
        dec_cnt[0] = 4; steps(2);
        dec_cnt[0] = 3; steps(1);
        dec_cnt[0] = 0; steps(2);

        // R3 cause priority and partial grants
        cur_req = "R3";
        free_all(0, 1, 1, 1); dec_cnt[0] = 3; steps(1);
        dec_cnt[0] = 0; free_all(0, 15, 15, 15); steps(4);
        free_all(0, 15, 2, 1); dec_cnt[0] = 4; steps(1);
        dec_cnt[0] = 0; free_all(0, 15, 15, 15); steps(4);
        free_all(0, 15, 15, 2); dec_cnt[0] = 4; steps(1);
        dec_cnt[0] = 0; free_all(0, 15, 15, 15); steps(4);

        // R5 stall requests fill the skid buffer, R7 threshold
        cur_req = "R5";
        stall_exe[0] = 1; dec_cnt[0] = 4; steps(2);
        stall_exe[0] = 0; stall_cmt[0] = 1; steps(1);
        dec_cnt[0] = 0; steps(2);

        // R6 release and drain, decode appended during unblocking
        cur_req = "R6";
        stall_cmt[0] = 0; steps(2);
        dec_cnt[0] = 2; steps(2);
        dec_cnt[0] = 0; steps(4);

        // R8 serialize wait released by the in-flight count
        cur_req = "R8";
        auto_land = 1'b0; land_cnt[0] = 0;
        dec_cnt[0] = 2; steps(1);
        rob_empty[0] = 0; ser_head[0] = 1; dec_cnt[0] = 1; steps(1);
        dec_cnt[0] = 0; steps(2);
        rob_empty[0] = 1; steps(1);
        land_cnt[0] = GW'(mn(m_f[0], W)); steps(1);
        land_cnt[0] = 0; steps(1);
        ser_head[0] = 0; auto_land = 1'b1; steps(4);

        // R9 serialize-after marks the next instruction
        cur_req = "R9";
        ser_after[0] = 1; steps(1);
        ser_after[0] = 0; dec_cnt[0] = 3; steps(1);
        dec_cnt[0] = 0; steps(5);

        // R10 in-flight count limits the grant
        cur_req = "R10";
        auto_land = 1'b0; land_cnt[0] = 0; free_all(0, 6, 6, 6);
        dec_cnt[0] = 4; steps(3);
        dec_cnt[0] = 0; land_cnt[0] = 3; steps(2);
        land_cnt[0] = 0; auto_land = 1'b1; free_all(0, 15, 15, 15); steps(5);

        // R11 squash with a full skid buffer
        cur_req = "R11";
        stall_exe[0] = 1; dec_cnt[0] = 4; steps(3);
        squash[0] = 1; steps(3);
        squash[0] = 0; steps(1);
        stall_exe[0] = 0; dec_cnt[0] = 0; steps(3);

        // long mixed run on both threads
        cur_req = "R6";
        for (int i = 0; i < 4000; i++) begin
            for (int t = 0; t < NT; t++) begin
                dec_cnt[t]   = (m_q[t] > SM - W) ? '0 : GW'($urandom_range(0, W));
                stall_exe[t] = ($urandom_range(0, 9) == 0);
                stall_cmt[t] = ($urandom_range(0, 14) == 0);
                squash[t]    = ($urandom_range(0, 40) == 0);
                rob_empty[t] = ($urandom_range(0, 2) != 0);
                ser_head[t]  = ($urandom_range(0, 11) == 0);
                ser_after[t] = ($urandom_range(0, 25) == 0);
                free_all(t, $urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 15));
            end
            auto_land = 1'b0;
            for (int t = 0; t < NT; t++) land_cnt[t] = GW'($urandom_range(0, mn(m_f[t], W)));
            step();
        end
        finish_run();
    end

endmodule